// File: doc/BRIEF.md
# Fast Interrupt Source Selector

This block picks one interrupt source out of 72 and sends it to a dedicated fast-interrupt line. The 72 sources arrive as three banks of raw pending levels: a 32-bit first bank, a 32-bit second bank and an 8-bit base bank. The sources are numbered in one flat space. The first bank takes indices 0 to 31, the second bank takes 32 to 63, and the base bank takes 64 to 71. An 8-bit control field holds a 7-bit source index and a generation enable. The field is written through a simple register port. The fast output follows the level of the chosen source while the enable is set.

The block also drives a one-hot vector in the flat order. The vector marks the source that is currently routed, so the normal-interrupt path can leave that source out. The block computes a normal-interrupt line from the raw levels and per-source normal enables. It applies no exclusion of its own. A source that is routed to the fast line and still enabled for normal delivery therefore raises both outputs.

Top module: `fast_irq_sel`

## Requirements
- R1: After reset the control readback is zero, `fiq_o` is low and `route_o` is all zero.
- R2: A write with `wr_en_i` high and `wr_addr_i` equal to 0x0C loads `wr_data_i[7:0]` into the control field at the clock edge. Writes to any other address leave the readback unchanged.
- R3: `rd_data_o` bits 31 to 8 always read zero, whatever value was written to them.
- R4: Control bits 6 to 0 hold the source index. Index k in 0..31 selects first-bank bit k. Index k in 32..63 selects second-bank bit k-32. Index k in 64..71 selects base-bank bit k-64.
- R5: Control bit 7 enables generation. When it is set and the index is valid, `fiq_o` follows the raw level of the selected source in the same cycle, without latching.
- R6: While control bit 7 is clear, `fiq_o` stays low and `route_o` is zero, whatever the index and the source levels.
- R7: Index values 72 to 127 select no source. For them `fiq_o` stays low and `route_o` is zero even when bit 7 is set.
- R8: When bit 7 is set and the index k is valid, `route_o` has exactly bit k set and no other bit.
- R9: `irq_o` is high when any source has both its raw level and its normal enable high. The fast configuration has no effect on it, so a routed source that is still normal-enabled raises `irq_o` and `fiq_o` together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write byte offset |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Control register readback |
| bank1_raw_i | input | 32 | First-bank raw levels (flat 0..31) |
| bank2_raw_i | input | 32 | Second-bank raw levels (flat 32..63) |
| bank0_raw_i | input | 8 | Base-bank raw levels (flat 64..71) |
| bank1_en_i | input | 32 | First-bank normal enables |
| bank2_en_i | input | 32 | Second-bank normal enables |
| bank0_en_i | input | 8 | Base-bank normal enables |
| fiq_o | output | 1 | Fast interrupt output |
| irq_o | output | 1 | Normal interrupt output |
| route_o | output | 72 | One-hot of the routed source, flat order |

## Verification
The assertions assume that the raw and enable inputs are ordinary level signals that settle before each sampling edge. They also assume that a write presents its address and data in the same cycle as its strobe. The bench changes every input at the falling clock edge and holds each write for exactly one cycle, so these assumptions hold throughout the run. Source levels are sometimes changed while the control field stays the same, to show that the fast line follows the level combinationally.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int unsigned B1_N    = 32;
  localparam int unsigned B2_N    = 32;
  localparam int unsigned B0_N    = 8;
  localparam int unsigned N_SRC   = B1_N + B2_N + B0_N;
  localparam int unsigned IDX_W   = 7;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam logic [ADDR_W-1:0] CTRL_OFF = 8'h0C;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } fsel_cfg_t;

  localparam int unsigned CFG_W = $bits(fsel_cfg_t);
endpackage

// File: rtl/fsel_ctrl_reg.sv
module fsel_ctrl_reg
  import fsel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output fsel_cfg_t         cfg_o,
  output logic [DATA_W-1:0] rd_data_o
);
  fsel_cfg_t cfg_q;
  logic      unused_hi;

  assign unused_hi = ^wr_data_i[DATA_W-1:CFG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i && (wr_addr_i == CTRL_OFF)) begin
      cfg_q <= fsel_cfg_t'(wr_data_i[CFG_W-1:0]);
    end
  end

  assign cfg_o     = cfg_q;
  assign rd_data_o = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
endmodule

// File: rtl/fsel_flatten.sv
module fsel_flatten
  import fsel_pkg::*;
(
  input  logic [B1_N-1:0]  bank1_raw_i,
  input  logic [B2_N-1:0]  bank2_raw_i,
  input  logic [B0_N-1:0]  bank0_raw_i,
  input  logic [B1_N-1:0]  bank1_en_i,
  input  logic [B2_N-1:0]  bank2_en_i,
  input  logic [B0_N-1:0]  bank0_en_i,
  output logic [N_SRC-1:0] flat_raw_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] flat_en;

  // flat order: first bank, second bank, base bank
  assign flat_raw_o = {bank0_raw_i, bank2_raw_i, bank1_raw_i};
  assign flat_en    = {bank0_en_i, bank2_en_i, bank1_en_i};
  assign irq_o      = |(flat_raw_o & flat_en);
endmodule

// File: rtl/fsel_route.sv
module fsel_route
  import fsel_pkg::*;
(
  input  fsel_cfg_t        cfg_i,
  input  logic [N_SRC-1:0] flat_raw_i,
  output logic [N_SRC-1:0] route_o,
  output logic             fiq_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_dec
    assign route_o[i] = cfg_i.en && (cfg_i.idx == IDX_W'(i));
  end

  assign fiq_o = |(route_o & flat_raw_i);
endmodule

// File: rtl/fast_irq_sel.sv
module fast_irq_sel
  import fsel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [B1_N-1:0]   bank1_raw_i,
  input  logic [B2_N-1:0]   bank2_raw_i,
  input  logic [B0_N-1:0]   bank0_raw_i,
  input  logic [B1_N-1:0]   bank1_en_i,
  input  logic [B2_N-1:0]   bank2_en_i,
  input  logic [B0_N-1:0]   bank0_en_i,
  output logic              fiq_o,
  output logic              irq_o,
  output logic [N_SRC-1:0]  route_o
);
  fsel_cfg_t        cfg;
  logic [N_SRC-1:0] flat_raw;

  fsel_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .rd_data_o (rd_data_o)
  );

  fsel_flatten u_flat (
    .bank1_raw_i (bank1_raw_i),
    .bank2_raw_i (bank2_raw_i),
    .bank0_raw_i (bank0_raw_i),
    .bank1_en_i  (bank1_en_i),
    .bank2_en_i  (bank2_en_i),
    .bank0_en_i  (bank0_en_i),
    .flat_raw_o  (flat_raw),
    .irq_o       (irq_o)
  );

  fsel_route u_route (
    .cfg_i      (cfg),
    .flat_raw_i (flat_raw),
    .route_o    (route_o),
    .fiq_o      (fiq_o)
  );
endmodule

// File: rtl/fast_irq_sel_chk.sv
module fast_irq_sel_chk
  import fsel_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [B1_N-1:0]   bank1_raw_i,
  input logic [B2_N-1:0]   bank2_raw_i,
  input logic [B0_N-1:0]   bank0_raw_i,
  input logic              fiq_o,
  input logic [N_SRC-1:0]  route_o
);
  logic [N_SRC-1:0] raw_all;
  assign raw_all = {bank0_raw_i, bank2_raw_i, bank1_raw_i};

  a_r2_other_addr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != CTRL_OFF) |=> $stable(rd_data_o));

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:CFG_W] == '0);

  a_r5_fiq_matches_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == |(route_o & raw_all));

  a_r6_off_no_fiq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[IDX_W] |-> (!fiq_o && route_o == '0));

  a_r7_range_no_fiq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[IDX_W-1:0] >= IDX_W'(N_SRC)) |-> (!fiq_o && route_o == '0));

  a_r8_route_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(route_o));

  a_r8_route_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[IDX_W] && rd_data_o[IDX_W-1:0] < IDX_W'(N_SRC))
      |-> ($countones(route_o) == 1));
endmodule

bind fast_irq_sel fast_irq_sel_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .rd_data_o   (rd_data_o),
  .bank1_raw_i (bank1_raw_i),
  .bank2_raw_i (bank2_raw_i),
  .bank0_raw_i (bank0_raw_i),
  .fiq_o       (fiq_o),
  .route_o     (route_o)
);

// File: tb/fast_irq_sel_tb.sv
`timescale 1ns/1ps
module fast_irq_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] b1_raw = '0, b2_raw = '0, b1_en = '0, b2_en = '0;
  logic [7:0]  b0_raw = '0, b0_en = '0;
  logic        fiq, irq;
  logic [71:0] route;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  fast_irq_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_data_o(rd_data),
    .bank1_raw_i(b1_raw), .bank2_raw_i(b2_raw), .bank0_raw_i(b0_raw),
    .bank1_en_i(b1_en), .bank2_en_i(b2_en), .bank0_en_i(b0_en),
    .fiq_o(fiq), .irq_o(irq), .route_o(route)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  function automatic logic [71:0] oh(input int k);
    return 72'(1) << k;
  endfunction

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 0);
    chk("R1 fiq", fiq, 0);
    chk("R1 route", route, 0);
  endtask

  task automatic t_other_addr;
    wr(8'h0C, 32'h85);
    chk("R2 write lands", rd_data, 32'h85);
    wr(8'h08, 32'h12);
    chk("R2 other addr ignored", rd_data, 32'h85);
    wr(8'h0D, 32'h00);
    chk("R2 near addr ignored", rd_data, 32'h85);
  endtask

  task automatic t_upper;
    wr(8'h0C, 32'hFFFF_FF83);
    chk("R3 upper bits zero", rd_data, 32'h83);
  endtask

  task automatic t_map;
    // R4 index 5 -> first bank bit 5
    wr(8'h0C, 32'h80 | 5);
    b1_raw = 32'h20; @(negedge clk);
    chk("R4 bank1 fiq", fiq, 1);
    chk("R8 bank1 route", route, oh(5));
    b1_raw = 32'hFFFF_FFDF; @(negedge clk);
    chk("R5 other bits no fiq", fiq, 0);
    b1_raw = '0;
    // index 37 -> second bank bit 5
    wr(8'h0C, 32'h80 | 37);
    b2_raw = 32'h20; @(negedge clk);
    chk("R4 bank2 fiq", fiq, 1);
    chk("R8 bank2 route", route, oh(37));
    b2_raw = '0; @(negedge clk);
    chk("R5 follows level low", fiq, 0);
    // index 67 -> base bank bit 3
    wr(8'h0C, 32'h80 | 67);
    b0_raw = 8'h08; @(negedge clk);
    chk("R4 bank0 fiq", fiq, 1);
    chk("R8 bank0 route", route, oh(67));
    b0_raw = '0;
    // boundaries 0, 63, 71
    wr(8'h0C, 32'h80);
    b1_raw = 32'h1; @(negedge clk);
    chk("R4 index 0", fiq, 1);
    b1_raw = '0;
    wr(8'h0C, 32'h80 | 63);
    b2_raw = 32'h8000_0000; @(negedge clk);
    chk("R4 index 63", fiq, 1);
    b2_raw = '0;
    wr(8'h0C, 32'h80 | 71);
    b0_raw = 8'h80; @(negedge clk);
    chk("R4 index 71", fiq, 1);
    chk("R8 index 71 route", route, oh(71));
    b0_raw = '0;
  endtask

  task automatic t_disabled;
    wr(8'h0C, 32'h05);
    b1_raw = 32'hFFFF_FFFF; b2_raw = 32'hFFFF_FFFF; b0_raw = 8'hFF;
    @(negedge clk);
    chk("R6 disabled fiq", fiq, 0);
    chk("R6 disabled route", route, 0);
  endtask

  task automatic t_range;
    wr(8'h0C, 32'h80 | 72);
    @(negedge clk);
    chk("R7 index 72 fiq", fiq, 0);
    chk("R7 index 72 route", route, 0);
    wr(8'h0C, 32'hFF);
    @(negedge clk);
    chk("R7 index 127 fiq", fiq, 0);
    chk("R7 index 127 route", route, 0);
    b1_raw = '0; b2_raw = '0; b0_raw = '0;
  endtask

  task automatic t_both;
    wr(8'h0C, 32'h80 | 40);
    b2_en = 32'h100; b2_raw = 32'h100; @(negedge clk);
    chk("R9 both fiq", fiq, 1);
    chk("R9 both irq", irq, 1);
    b2_en = '0; @(negedge clk);
    chk("R9 fiq only", fiq, 1);
    chk("R9 irq low when not enabled", irq, 0);
    b2_raw = '0; b0_raw = 8'h02; b0_en = 8'h02; @(negedge clk);
    chk("R9 irq other source", irq, 1);
    chk("R9 fiq low other source", fiq, 0);
    b0_raw = '0; b0_en = '0;
  endtask

  initial begin
    #1 t_reset;
    #10 rst_n = 1'b1;
    t_other_addr;
    t_upper;
    t_map;
    t_disabled;
    t_range;
    t_both;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule